// File: doc/BRIEF.md
# Sequential Exponential Decay Evaluator

This block computes exp(-u) for a non-negative fixed-point argument. It is meant to be the activation stage of a Gaussian radial-basis neuron, where the argument is the scaled squared distance between the input and the neuron centre. A caller pulses `start` with the argument on `arg_in`. The block answers with a one-cycle `done` pulse, and at that moment `result` holds exp(-u) as a Q15 fraction.

Arguments of 4 or more produce zero at once. Below 4, the argument is first divided by four, giving r. The block then evaluates a 12th-order truncated Taylor polynomial of exp(-4r). That polynomial is scaled down by 16 so that no intermediate value leaves the Q15 range. Evaluation uses Horner's rule, one multiply or one add per clock, with a single multiplier and a single adder. A 4-bit left shift with saturation restores the scale at the end.

The controller has seven states:
- `ST_IDLE` waits for `start`.
- `ST_RANGE` compares the argument against 4. It goes to `ST_FINISH` with a zero result when the argument is out of range, and to `ST_NORM` otherwise.
- `ST_NORM` loads the top coefficient and the normalised argument.
- `ST_MUL` and `ST_ADD` alternate, twelve times each. `ST_MUL` goes to `ST_ADD`. `ST_ADD` goes back to `ST_MUL` while lower coefficients remain, and to `ST_SCALE` after the constant term has been added.
- `ST_SCALE` applies the shift and the clamp.
- `ST_FINISH` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `exp_decay_eval`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: `arg_in` is unsigned with 13 fractional bits, so u = arg_in / 8192 and bit 15 has weight 4. When bit 15 is set (u >= 4), the block returns `result` = 0.
- R3: For u < 4, `result` is within 128 LSB of 32768·16·Σ_{n=0..12} a_n·r^n, where r = u/4 and a_n = (-1)^n·4^(n-2)/n!. The expected value is clamped to the range [0, 32767] before the comparison.
- R4: For u < 4, `result` is also within 512 LSB of 32768·exp(-u), clamped to at most 32767.
- R5: When the rescaled value reaches 1.0 or more, as it does at u = 0, `result` saturates to 32767. `result` never has bit 15 set.
- R6: No Horner addition ever overflows the 16-bit two's-complement accumulator.
- R7: `done` is high for exactly one clock cycle per accepted `start`.
- R8: Latency is counted in rising edges after the edge that samples `start`. For u < 4, `done` is high in the cycle that follows the 27th such edge. For u >= 4, it is high in the cycle that follows the 1st such edge.
- R9: A `start` that arrives while a computation is in progress is ignored. It does not change the result, and it does not produce an extra `done`.
- R10: `result` holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an evaluation of `arg_in` (sampled in idle only) |
| arg_in | input | 16 | Argument u, unsigned, 13 fractional bits |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | exp(-u) in Q15, valid from `done` until the next completion |

## Verification
The bench sweeps the in-range argument space in fine steps and checks each result twice: against the ideal truncated polynomial and against the true exponential. A wrong coefficient, a missing rounding step or a misplaced shift therefore shows up as a drift of hundreds of LSB somewhere in the sweep. Zero and tiny arguments target the saturation path: an unclamped shift would wrap the output to a large negative value. Arguments just at and above 4 target the comparator: an off-by-one bit there would return a Taylor value instead of zero. A second start pulse fired in the middle of a computation shows whether the argument register or the sequencer can be disturbed while busy, which would appear as a wrong value or a second `done` pulse.

// File: rtl/exp_eval_pkg.sv
package exp_eval_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RANGE,
        ST_NORM,
        ST_MUL,
        ST_ADD,
        ST_SCALE,
        ST_FINISH
    } exp_state_e;

    // Coefficient n of the pre-scaled series, as an integer with frac_bits
    // fractional bits: (-1)^n * 2^(2n + frac_bits - pre_shift) / n!, rounded.
    function automatic longint coef_fixed(input int n, input int frac_bits, input int pre_shift);
        longint fact;
        longint num;
        longint q;
        fact = 1;
        for (int k = 2; k <= n; k++) fact = fact * longint'(k);
        num = longint'(1) << (2 * n + frac_bits - pre_shift);
        q   = (num + fact / 2) / fact;
        return (n % 2 == 1) ? -q : q;
    endfunction

endpackage

// File: rtl/exp_coef_rom.sv
module exp_coef_rom #(
    parameter int DATA_W    = 16,
    parameter int ORDER     = 12,
    parameter int PRE_SHIFT = 4,
    localparam int IDX_W    = $clog2(ORDER + 1)
) (
    input  logic [IDX_W-1:0]         idx,
    output logic signed [DATA_W-1:0] coef
);
    import exp_eval_pkg::*;

    localparam int FRAC_W = DATA_W - 1;

    logic signed [DATA_W-1:0] tbl [ORDER+1];

    for (genvar g = 0; g <= ORDER; g++) begin : g_coef
        assign tbl[g] = DATA_W'(coef_fixed(g, FRAC_W, PRE_SHIFT));
    end

    always_comb begin
        if (32'(idx) > ORDER) coef = '0;
        else                  coef = tbl[idx];
    end

endmodule

// File: rtl/exp_horner_alu.sv
module exp_horner_alu #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] acc,
    input  logic signed [DATA_W-1:0] mul_r,
    input  logic signed [DATA_W-1:0] coef,
    output logic signed [DATA_W-1:0] prod_q,
    output logic signed [DATA_W:0]   sum_w
);
    localparam int FRAC_W = DATA_W - 1;
    localparam logic signed [2*DATA_W-1:0] HALF_LSB = (2*DATA_W)'(1) << (FRAC_W - 1);

    logic signed [2*DATA_W-1:0] prod_full;
    logic signed [2*DATA_W-1:0] prod_rnd;

    // single multiplier, rounded back to Q15
    assign prod_full = acc * mul_r;
    assign prod_rnd  = prod_full + HALF_LSB;
    assign prod_q    = DATA_W'(prod_rnd >>> FRAC_W);

    // single adder, one guard bit for overflow observation
    assign sum_w = {acc[DATA_W-1], acc} + {coef[DATA_W-1], coef};

endmodule

// File: rtl/exp_out_scaler.sv
module exp_out_scaler #(
    parameter int DATA_W    = 16,
    parameter int PRE_SHIFT = 4
) (
    input  logic signed [DATA_W-1:0] acc,
    output logic        [DATA_W-1:0] res
);
    localparam logic [DATA_W-1:0] LIMIT   = DATA_W'(1) << (DATA_W - 1 - PRE_SHIFT);
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};

    always_comb begin
        if (acc[DATA_W-1])                 res = '0;
        else if (DATA_W'(acc) >= LIMIT)    res = POS_MAX;
        else                               res = DATA_W'(acc) << PRE_SHIFT;
    end

endmodule

// File: rtl/exp_decay_eval.sv
module exp_decay_eval #(
    parameter int DATA_W    = 16,
    parameter int ORDER     = 12,
    parameter int PRE_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] arg_in,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    import exp_eval_pkg::*;

    localparam int IDX_W = $clog2(ORDER + 1);
    localparam int MSB   = DATA_W - 1;

    exp_state_e state_q, state_d;

    logic [DATA_W-1:0]        arg_q;
    logic signed [DATA_W-1:0] r_q;
    logic signed [DATA_W-1:0] acc_q;
    logic [IDX_W-1:0]         idx_q;
    logic [DATA_W-1:0]        res_q;

    logic signed [DATA_W-1:0] coef;
    logic signed [DATA_W-1:0] prod_q;
    logic signed [DATA_W:0]   sum_w;
    logic [DATA_W-1:0]        scaled;

    exp_coef_rom #(.DATA_W(DATA_W), .ORDER(ORDER), .PRE_SHIFT(PRE_SHIFT)) u_rom (
        .idx  (idx_q),
        .coef (coef)
    );

    exp_horner_alu #(.DATA_W(DATA_W)) u_alu (
        .acc    (acc_q),
        .mul_r  (r_q),
        .coef   (coef),
        .prod_q (prod_q),
        .sum_w  (sum_w)
    );

    exp_out_scaler #(.DATA_W(DATA_W), .PRE_SHIFT(PRE_SHIFT)) u_scale (
        .acc (acc_q),
        .res (scaled)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RANGE;
            ST_RANGE:  state_d = arg_q[MSB] ? ST_FINISH : ST_NORM;
            ST_NORM:   state_d = ST_MUL;
            ST_MUL:    state_d = ST_ADD;
            ST_ADD:    state_d = (idx_q == '0) ? ST_SCALE : ST_MUL;
            ST_SCALE:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q <= '0;
            r_q   <= '0;
            acc_q <= '0;
            idx_q <= '0;
            res_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) arg_q <= arg_in;
                end
                ST_RANGE: begin
                    idx_q <= IDX_W'(ORDER);
                    if (arg_q[MSB]) res_q <= '0;
                end
                ST_NORM: begin
                    // u/4: Q2.13 reinterpreted as Q15 (binary point moves two places)
                    r_q   <= {1'b0, arg_q[MSB-1:0]};
                    acc_q <= coef;
                    idx_q <= idx_q - 1'b1;
                end
                ST_MUL: begin
                    acc_q <= prod_q;
                end
                ST_ADD: begin
                    acc_q <= sum_w[DATA_W-1:0];
                    if (idx_q != '0) idx_q <= idx_q - 1'b1;
                end
                ST_SCALE: begin
                    res_q <= scaled;
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    assign done   = (state_q == ST_FINISH);
    assign result = res_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADD) |-> (sum_w[DATA_W] == sum_w[DATA_W-1])); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RANGE && arg_q[MSB]) |=> (done && result == '0)); // R2

    AST_BUSY_ARG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(arg_q)); // R9

    AST_RESULT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !result[MSB]); // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SCALE && state_q != ST_RANGE) |=> $stable(result)); // R10

endmodule

// File: tb/exp_decay_eval_test.sv
`timescale 1ns/1ps
module exp_decay_eval_test;

    localparam int TOL_POLY = 128;
    localparam int TOL_EXP  = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] arg_in = '0;
    logic        done;
    logic [15:0] result;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    exp_decay_eval uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .arg_in (arg_in),
        .done   (done),
        .result (result)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected<=190000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic real coef_real(input int n);
        real f = 1.0;
        for (int k = 2; k <= n; k++) f = f * k;
        return ((n % 2 == 1) ? -1.0 : 1.0) * (4.0 ** (n - 2)) / f;
    endfunction

    function automatic int clamp_q15(input real v);
        if (v < 0.0) return 0;
        if (v > 32767.0) return 32767;
        return $rtoi(v + 0.5);
    endfunction

    function automatic int poly_ref(input int a);
        real r = a / 32768.0;
        real s = 0.0;
        for (int n = 12; n >= 0; n--) s = s * r + coef_real(n);
        return clamp_q15(16.0 * s * 32768.0);
    endfunction

    function automatic int exp_ref(input int a);
        return clamp_q15($exp(-(a / 8192.0)) * 32768.0);
    endfunction

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // issue start, return edges-after-sampling-edge latency and result
    task automatic run(input logic [15:0] a, output int lat, output int res);
        int n = 0;
        @(negedge clk);
        start  = 1'b1;
        arg_in = a;
        lat = -1;
        res = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            n++;
            if (done) begin
                lat = n - 1;
                res = int'(result);
                break;
            end
            if (n > 100) break;
        end
    endtask

    task automatic eval_check(input logic [15:0] a);
        int lat, res;
        run(a, lat, res);
        if (a[15]) begin
            chk(res == 0, "R2", res, 0);
            chk(lat == 1, "R8", lat, 1);
        end else begin
            chk(absi(res - poly_ref(a)) <= TOL_POLY, "R3", res, poly_ref(a));
            chk(absi(res - exp_ref(a)) <= TOL_EXP, "R4", res, exp_ref(a));
            chk(lat == 27, "R8", lat, 27);
        end
        @(negedge clk);
        chk(!done, "R7", int'(done), 0);
    endtask

    initial begin
        int lat, res, held, dones;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!done, "R1", int'(done), 0);
        chk(result == 16'd0, "R1", int'(result), 0);
        rst_n = 1'b1;

        // R5 saturation at and near zero
        run(16'd0, lat, res);
        chk(res == 32767, "R5", res, 32767);
        run(16'd1, lat, res);
        chk(res == 32767, "R5", res, 32767);

        // R2 out of range
        eval_check(16'h8000);
        eval_check(16'h8001);
        eval_check(16'd40000);
        eval_check(16'hFFFF);
        // just below 4
        eval_check(16'h7FFF);

        // R3 R4 R8 near-exhaustive sweep of the in-range space
        for (int a = 0; a < 32768; a += 37) eval_check(16'(a));

        // R10 result held while idle
        run(16'd8192, lat, res);
        repeat (10) @(negedge clk);
        held = int'(result);
        chk(held == res, "R10", held, res);

        // R9 start while busy ignored
        @(negedge clk);
        start = 1'b1; arg_in = 16'd0;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int i = 0; i < 60; i++) begin
            if (i == 5) begin start = 1'b1; arg_in = 16'd30000; end
            if (i == 6) start = 1'b0;
            @(negedge clk);
            if (done) begin
                dones++;
                res = int'(result);
            end
        end
        chk(dones == 1, "R9", dones, 1);
        chk(res == 32767, "R9", res, 32767);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule